// File: doc/BRIEF.md
# Character Display Command Executor

This block sits between a host register port and the memories of a one-line character display. It decodes 8-bit instruction bytes and data bytes written by the host. It keeps the address counter, the entry mode, the display, cursor and blink control bits, the bus-width flag, the display view offset and the busy flag. It turns accepted operations into write and read requests on a shared RAM port. That port reaches a 32-entry display RAM and a 16-byte user pattern RAM, and a select bit picks between them.

The block also runs the timed blanking sequence. This sequence follows reset and every clear instruction. It writes the blank code 20h into every display RAM entry, one per cycle, and then holds busy for a programmable number of extra cycles. The bus protocol and the panel scan are outside this block. The scan logic reads the control outputs and the view offset. The host must leave at least four clock cycles between accepted operations so that a read-ahead can complete before the next operation begins.

Top module: `chr_cmd_exec`

## Requirements
- R1: While reset is low and for exactly 32+HOLD_CYCLES cycles after its release, status bit 7 (busy) is 1. During the first 32 of those cycles every display RAM entry is written with 20h. After reset the display, cursor and blink bits are 0, increment mode and 8-bit mode are 1, shift-on-write is 0, and the address counter, view offset and read register are all 0.
- R2: Instruction 01h writes 20h to all 32 display RAM entries and holds busy for 32+HOLD_CYCLES cycles. It sets the address counter to 0 in display RAM mode, clears the view offset and forces increment mode.
- R3: While busy, host writes and data reads have no effect on any state or RAM. The status output is always {busy, 2'b00, address counter[4:0]}.
- R4: Instructions 02h and 03h set the address counter to 0 in display RAM mode and clear the view offset. RAM contents are left unchanged.
- R5: Instruction 0000_01ab sets increment mode to a and shift-on-write to b. After each data write or data read, the address counter steps by +1 when a=1 and by -1 when a=0. In display RAM mode it wraps modulo 32.
- R6: A data write in display RAM mode with shift-on-write=1 changes the view offset by +1 (a=1, shift left) or by -1 (a=0, shift right), modulo 32. Data reads and pattern RAM writes never change the view offset.
- R7: Instruction 0000_1dcb sets display-on to d, cursor-on to c and blink-on to b.
- R8: Instruction 0001_sr00 with s=0 moves the cursor: r=1 increments the address counter and r=0 decrements it. With s=1 it changes the view offset by -1 (r=1, right) or by +1 (r=0, left) and leaves the counter unchanged.
- R9: Instruction 001d_xxxx sets the 8-bit bus flag to d.
- R10: Instruction 01xx_aaaa selects pattern RAM and loads the counter with aaaa. In pattern RAM mode the counter wraps modulo 16, and RAM requests carry the select bit set to 1.
- R11: Instruction 1xxa_aaaa selects display RAM and loads the counter with a_aaaa.
- R12: An address load, a data read, or a cursor move in display RAM mode issues a read-ahead of the RAM byte at the new counter value one cycle later. That byte appears on the read register output one cycle after that. A data read therefore returns the byte held before the read and then fetches the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | One-cycle host write strobe |
| host_rd | input | 1 | One-cycle host read strobe |
| host_rs | input | 1 | 0 selects instruction/status, 1 selects data |
| host_wdata | input | 8 | Instruction or data byte |
| status | output | 8 | {busy, 2'b00, address counter} |
| rd_q | output | 8 | Read register (read-ahead byte) |
| ram_we | output | 1 | RAM write request |
| ram_re | output | 1 | RAM read request |
| ram_sel | output | 1 | 0 display RAM, 1 pattern RAM |
| ram_addr | output | 5 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid the cycle after ram_re |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Cursor blink enable |
| inc_mode | output | 1 | Counter steps up after RAM access |
| shift_on_write | output | 1 | View shifts on display RAM writes |
| bus_8bit | output | 1 | Bus width flag |
| view_ofs | output | 5 | Display view offset |

## Verification
A wrong counter or select bit appears on the status byte in the cycle after the operation. It appears as a wrong read-ahead byte on rd_q two cycles later. A fault in the blanking sequence shows up in two ways: the busy window has the wrong length, or a later read-back of the display RAM finds bytes that are not 20h. A wrong view offset or mode bit can be seen on its own output in the cycle after the instruction. Faults that only move the offset on a write surface after the next display write.

// File: rtl/chr_cmd_pkg.sv
// Shared types and constants for the character display command executor.
// Assumes instruction bytes are classified by their leading one bit.
package chr_cmd_pkg;

    typedef enum logic [3:0] {
        K_NOP,
        K_CLEAR,
        K_HOME,
        K_ENTRY,
        K_DISP,
        K_MOVE,
        K_WIDTH,
        K_PADDR,
        K_DADDR
    } cmd_kind_e;

    localparam logic [7:0] BLANK_CODE = 8'h20;

endpackage

// File: rtl/chr_cmd_decode.sv
// Instruction classifier: maps an instruction byte to its kind by the
// position of its most significant set bit. Purely combinational.
module chr_cmd_decode
    import chr_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_kind_e  kind
);

    // Priority classify on the leading one
    always_comb begin
        if (code[7])      kind = K_DADDR;
        else if (code[6]) kind = K_PADDR;
        else if (code[5]) kind = K_WIDTH;
        else if (code[4]) kind = K_MOVE;
        else if (code[3]) kind = K_DISP;
        else if (code[2]) kind = K_ENTRY;
        else if (code[1]) kind = K_HOME;
        else if (code[0]) kind = K_CLEAR;
        else              kind = K_NOP;
    end

endmodule

// File: rtl/chr_clear_seq.sv
// Blanking sequencer: after reset or a start pulse, asserts busy for
// DEPTH+HOLD cycles and drives one fill write per cycle for the first DEPTH.
// Assumes start is only raised while idle.
module chr_clear_seq #(
    parameter int DEPTH = 32,
    parameter int HOLD  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    output logic                     busy,
    output logic                     fill_we,
    output logic [$clog2(DEPTH)-1:0] fill_addr
);

    localparam int TOTAL = DEPTH + HOLD;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(TOTAL + 1);

    logic          active;
    logic [CW-1:0] cnt;

    // Run counter: starts active out of reset, restarts on a start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == CW'(TOTAL - 1)) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end
    end

    assign busy      = active;
    assign fill_we   = active && (cnt < CW'(DEPTH));
    assign fill_addr = cnt[AW-1:0];

endmodule

// File: rtl/chr_addr_unit.sv
// Address counter with RAM select and the view offset register.
// Assumes load, step and home are mutually exclusive per cycle; pattern
// mode keeps the counter below 2**PAW.
module chr_addr_unit #(
    parameter int AW  = 5,
    parameter int PAW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          home,
    input  logic          load_en,
    input  logic          load_sel,
    input  logic [AW-1:0] load_val,
    input  logic          step_en,
    input  logic          step_up,
    input  logic          shf_en,
    input  logic          shf_left,
    output logic [AW-1:0] ac,
    output logic          sel,
    output logic [AW-1:0] ofs
);

    localparam logic [AW-1:0] PMASK = AW'((1 << PAW) - 1);

    logic [AW-1:0] stepped;

    // Next counter value for a step, wrapped to the active RAM size
    always_comb begin
        stepped = step_up ? ac + 1'b1 : ac - 1'b1;
        if (sel) stepped = stepped & PMASK;
    end

    // Counter and RAM select update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac  <= '0;
            sel <= 1'b0;
        end else if (home) begin
            ac  <= '0;
            sel <= 1'b0;
        end else if (load_en) begin
            ac  <= load_sel ? (load_val & PMASK) : load_val;
            sel <= load_sel;
        end else if (step_en) begin
            ac <= stepped;
        end
    end

    // View offset: left shift adds one, right shift subtracts one
    always_ff @(posedge clk) begin
        if (!rst_n || home) begin
            ofs <= '0;
        end else if (shf_en) begin
            ofs <= shf_left ? ofs + 1'b1 : ofs - 1'b1;
        end
    end

endmodule

// File: rtl/chr_cmd_exec.sv
// Character display command executor top. Accepts host instruction and
// data strobes, keeps mode state, drives a shared RAM port and runs the
// blanking sequence. Assumes at least four cycles between host operations
// and RAM read data valid one cycle after ram_re.
module chr_cmd_exec
    import chr_cmd_pkg::*;
#(
    parameter int AW          = 5,
    parameter int PAW         = 4,
    parameter int DW          = 8,
    parameter int HOLD_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          host_rs,
    input  logic [7:0]    host_wdata,
    output logic [DW-1:0] status,
    output logic [DW-1:0] rd_q,
    output logic          ram_we,
    output logic          ram_re,
    output logic          ram_sel,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata,
    output logic          disp_on,
    output logic          cursor_on,
    output logic          blink_on,
    output logic          inc_mode,
    output logic          shift_on_write,
    output logic          bus_8bit,
    output logic [AW-1:0] view_ofs
);

    localparam int DEPTH = 1 << AW;

    cmd_kind_e     kind;
    logic          busy;
    logic          fill_we;
    logic [AW-1:0] fill_addr;
    logic [AW-1:0] ac;
    logic          sel;
    logic          cmd_wr, dat_wr, dat_rd;
    logic          is_cursor, is_view;
    logic          home, load_en, load_sel, step_en, step_up, shf_en, shf_left;
    logic [AW-1:0] load_val;
    logic          fetch_go;
    logic          pf_req, rd_vld;

    chr_cmd_decode u_dec (
        .code (host_wdata),
        .kind (kind)
    );

    chr_clear_seq #(.DEPTH(DEPTH), .HOLD(HOLD_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_wr && (kind == K_CLEAR)),
        .busy      (busy),
        .fill_we   (fill_we),
        .fill_addr (fill_addr)
    );

    // Host operation qualification: nothing but status while busy
    always_comb begin
        cmd_wr    = host_wr && !host_rs && !busy;
        dat_wr    = host_wr &&  host_rs && !busy;
        dat_rd    = host_rd &&  host_rs && !busy;
        is_cursor = cmd_wr && (kind == K_MOVE) && !host_wdata[3];
        is_view   = cmd_wr && (kind == K_MOVE) &&  host_wdata[3];
    end

    // Address unit control derived from the accepted operation
    always_comb begin
        home     = cmd_wr && ((kind == K_HOME) || (kind == K_CLEAR));
        load_en  = cmd_wr && ((kind == K_PADDR) || (kind == K_DADDR));
        load_sel = (kind == K_PADDR);
        load_val = (kind == K_PADDR) ? AW'(host_wdata[PAW-1:0])
                                     : host_wdata[AW-1:0];
        step_en  = dat_wr || dat_rd || is_cursor;
        step_up  = cmd_wr ? host_wdata[2] : inc_mode;
        shf_en   = (dat_wr && !sel && shift_on_write) || is_view;
        shf_left = cmd_wr ? !host_wdata[2] : inc_mode;
        fetch_go = load_en || dat_rd || (is_cursor && !sel);
    end

    chr_addr_unit #(.AW(AW), .PAW(PAW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .home     (home),
        .load_en  (load_en),
        .load_sel (load_sel),
        .load_val (load_val),
        .step_en  (step_en),
        .step_up  (step_up),
        .shf_en   (shf_en),
        .shf_left (shf_left),
        .ac       (ac),
        .sel      (sel),
        .ofs      (view_ofs)
    );

    // Mode bits: entry, display control and bus width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_mode       <= 1'b1;
            shift_on_write <= 1'b0;
            disp_on        <= 1'b0;
            cursor_on      <= 1'b0;
            blink_on       <= 1'b0;
            bus_8bit       <= 1'b1;
        end else if (cmd_wr) begin
            case (kind)
                K_CLEAR: inc_mode <= 1'b1;
                K_ENTRY: begin
                    inc_mode       <= host_wdata[1];
                    shift_on_write <= host_wdata[0];
                end
                K_DISP: begin
                    disp_on   <= host_wdata[2];
                    cursor_on <= host_wdata[1];
                    blink_on  <= host_wdata[0];
                end
                K_WIDTH: bus_8bit <= host_wdata[4];
                default: ;
            endcase
        end
    end

    // Read-ahead pipeline: request, RAM latency, capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_req <= 1'b0;
            rd_vld <= 1'b0;
            rd_q   <= '0;
        end else begin
            pf_req <= fetch_go;
            rd_vld <= ram_re;
            if (rd_vld) rd_q <= ram_rdata;
        end
    end

    // Shared RAM port: the fill sequence owns it while running
    always_comb begin
        ram_we    = fill_we || dat_wr;
        ram_re    = pf_req && !fill_we;
        ram_sel   = fill_we ? 1'b0 : sel;
        ram_addr  = fill_we ? fill_addr : ac;
        ram_wdata = fill_we ? DW'(BLANK_CODE) : DW'(host_wdata);
    end

    assign status = {busy, {(DW-1-AW){1'b0}}, ac};

endmodule

// File: rtl/chr_cmd_exec_chk.sv
// Property checker for the command executor, bound to every instance.
// Observes only top-level ports.
module chr_cmd_exec_chk #(
    parameter int AW  = 5,
    parameter int PAW = 4,
    parameter int DW  = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr,
    input logic          host_rs,
    input logic [7:0]    host_wdata,
    input logic [DW-1:0] status,
    input logic          ram_we,
    input logic          ram_re,
    input logic          ram_sel,
    input logic [AW-1:0] ram_addr,
    input logic [DW-1:0] ram_wdata,
    input logic          disp_on,
    input logic          inc_mode,
    input logic [AW-1:0] view_ofs
);

    logic bz;
    assign bz = status[DW-1];

    // R2: an accepted clear raises busy and homes everything
    a_r2_clear_homes: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rs && host_wdata == 8'h01 && !bz)
        |=> (bz && status[AW-1:0] == '0 && view_ofs == '0 && inc_mode));

    // R3: while busy the RAM only sees blank fill writes to display RAM
    a_r3_busy_fill_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bz && ram_we) |-> (ram_wdata == DW'(8'h20) && !ram_sel));

    // R3: writes attempted while busy leave control state untouched
    a_r3_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (bz && host_wr) |=> ($stable(disp_on) && $stable(view_ofs)));

    // R4: return home zeroes the counter and offset
    a_r4_home: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rs && host_wdata[7:1] == 7'b0000001 && !bz)
        |=> (status[AW-1:0] == '0 && view_ofs == '0));

    // R5: increment-mode display write advances the counter by one
    a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_rs && !bz && inc_mode && !ram_sel)
        |=> (status[AW-1:0] == AW'($past(status[AW-1:0]) + 1'b1)));

    // R10: pattern RAM requests stay inside the pattern range
    a_r10_pattern_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel && (ram_we || ram_re)) |-> (ram_addr[AW-1:PAW] == '0));

    // R12: a display address load is followed by a read-ahead of that address
    a_r12_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rs && host_wdata[7] && !bz)
        |=> (ram_re && !ram_sel && ram_addr == $past(host_wdata[AW-1:0])));

endmodule

bind chr_cmd_exec chr_cmd_exec_chk #(.AW(AW), .PAW(PAW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rs    (host_rs),
    .host_wdata (host_wdata),
    .status     (status),
    .ram_we     (ram_we),
    .ram_re     (ram_re),
    .ram_sel    (ram_sel),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .disp_on    (disp_on),
    .inc_mode   (inc_mode),
    .view_ofs   (view_ofs)
);

// File: tb/sim_chr_cmd_exec.sv
module sim_chr_cmd_exec;

    localparam int HOLD  = 16;
    localparam int TOTAL = 32 + HOLD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_rs = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] status, rd_q, ram_wdata, ram_rdata;
    logic       ram_we, ram_re, ram_sel;
    logic [4:0] ram_addr, view_ofs;
    logic       disp_on, cursor_on, blink_on, inc_mode, shift_on_write, bus_8bit;

    always #5 clk = ~clk;

    chr_cmd_exec #(.HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_rs(host_rs), .host_wdata(host_wdata), .status(status), .rd_q(rd_q),
        .ram_we(ram_we), .ram_re(ram_re), .ram_sel(ram_sel), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .disp_on(disp_on),
        .cursor_on(cursor_on), .blink_on(blink_on), .inc_mode(inc_mode),
        .shift_on_write(shift_on_write), .bus_8bit(bus_8bit), .view_ofs(view_ofs)
    );

    // RAM model: synchronous write, registered read
    logic [7:0] dram [32];
    logic [7:0] pram [16];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) pram[i] <= 8'h00;
        end
        if (ram_we) begin
            if (ram_sel) pram[ram_addr[3:0]] <= ram_wdata;
            else         dram[ram_addr]      <= ram_wdata;
        end
        if (ram_re) ram_rdata <= ram_sel ? pram[ram_addr[3:0]] : dram[ram_addr];
    end

    // Expected model
    logic [7:0] e_d [32];
    logic [7:0] e_p [16];
    logic [4:0] e_ac, e_ofs;
    logic       e_sel, e_id, e_sh, e_dd, e_cc, e_bb, e_dl;
    logic [7:0] e_out;
    int nchk = 0, nfail = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] f_step(logic [4:0] a, logic s, logic up);
        logic [4:0] n;
        n = up ? a + 5'd1 : a - 5'd1;
        if (s) n[4] = 1'b0;
        return n;
    endfunction

    function automatic logic [7:0] f_mem(logic s, logic [4:0] a);
        return s ? e_p[a[3:0]] : e_d[a];
    endfunction

    task automatic m_reset();
        e_ac = 0; e_ofs = 0; e_sel = 0; e_id = 1; e_sh = 0;
        e_dd = 0; e_cc = 0; e_bb = 0; e_dl = 1; e_out = 0;
        for (int i = 0; i < 32; i++) e_d[i] = 8'h20;
        for (int i = 0; i < 16; i++) e_p[i] = 8'h00;
    endtask

    task automatic m_cmd(input logic [7:0] v);
        casez (v)
            8'b1???????: begin e_ac = v[4:0]; e_sel = 0; e_out = f_mem(0, e_ac); end
            8'b01??????: begin e_ac = {1'b0, v[3:0]}; e_sel = 1; e_out = f_mem(1, e_ac); end
            8'b001?????: e_dl = v[4];
            8'b0001????: begin
                if (v[3]) e_ofs = v[2] ? e_ofs - 5'd1 : e_ofs + 5'd1;
                else begin
                    e_ac = f_step(e_ac, e_sel, v[2]);
                    if (!e_sel) e_out = f_mem(0, e_ac);
                end
            end
            8'b00001???: begin e_dd = v[2]; e_cc = v[1]; e_bb = v[0]; end
            8'b000001??: begin e_id = v[1]; e_sh = v[0]; end
            8'b0000001?: begin e_ac = 0; e_sel = 0; e_ofs = 0; end
            8'b00000001: begin
                for (int i = 0; i < 32; i++) e_d[i] = 8'h20;
                e_ac = 0; e_sel = 0; e_ofs = 0; e_id = 1;
            end
            default: ;
        endcase
    endtask

    task automatic m_wr(input logic [7:0] v);
        if (e_sel) e_p[e_ac[3:0]] = v; else e_d[e_ac] = v;
        if (!e_sel && e_sh) e_ofs = e_id ? e_ofs + 5'd1 : e_ofs - 5'd1;
        e_ac = f_step(e_ac, e_sel, e_id);
    endtask

    task automatic m_rd();
        e_ac = f_step(e_ac, e_sel, e_id);
        e_out = f_mem(e_sel, e_ac);
    endtask

    task automatic pulse(input logic wr, input logic rd, input logic rs, input logic [7:0] v);
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_rs = rs; host_wdata = v;
        @(negedge clk);
        host_wr = 0; host_rd = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_state(input string tag);
        chk({tag, " status"}, status, {3'b000, e_ac});
        chk({tag, " ofs"}, view_ofs, e_ofs);
        chk({tag, " modes"}, {inc_mode, shift_on_write, disp_on, cursor_on, blink_on, bus_8bit},
            {e_id, e_sh, e_dd, e_cc, e_bb, e_dl});
        chk({tag, " rd_q"}, rd_q, e_out);
    endtask

    task automatic op_cmd(input string tag, input logic [7:0] v);
        m_cmd(v); pulse(1, 0, 0, v); check_state(tag);
    endtask

    task automatic op_wr(input string tag, input logic [7:0] v);
        m_wr(v); pulse(1, 0, 1, v); check_state(tag);
    endtask

    task automatic op_rd(input string tag);
        chk({tag, " read value"}, rd_q, e_out);
        m_rd(); pulse(0, 1, 1, 8'h00); check_state(tag);
    endtask

    // Clear with optional probes driven during the busy window
    task automatic op_clear(input bit probe);
        int n;
        m_cmd(8'h01);
        @(negedge clk); host_wr = 1; host_rs = 0; host_wdata = 8'h01;
        @(negedge clk); host_wr = 0;
        n = 0;
        while (status[7] && n < 1000) begin
            n++;
            if (n == 1) chk("R3 status while busy", status, 8'h80);
            host_wr = 0; host_rd = 0;
            if (probe) begin
                case (n)
                    5:  begin host_wr = 1; host_rs = 0; host_wdata = 8'h0F; end
                    10: begin host_wr = 1; host_rs = 1; host_wdata = 8'h55; end
                    20: begin host_rd = 1; host_rs = 1; end
                    40: begin host_wr = 1; host_rs = 0; host_wdata = 8'h85; end
                    default: ;
                endcase
            end
            @(negedge clk);
        end
        host_wr = 0; host_rd = 0;
        chk("R2 busy length after clear", n, TOTAL);
        repeat (2) @(negedge clk);
        check_state(probe ? "R3 busy ignored" : "R2 clear");
    endtask

    task automatic readback(input string tag);
        op_cmd(tag, 8'h06);
        op_cmd(tag, 8'h80);
        for (int i = 0; i < 32; i++) op_rd(tag);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h5EED_0042));
        m_reset();
        repeat (3) @(negedge clk);
        chk("R1 busy during reset", status[7], 1'b1);
        rst_n = 1;
        n = 0;
        while (status[7] && n < 1000) begin n++; @(negedge clk); end
        chk("R1 busy length after reset", n, TOTAL);
        check_state("R1 reset defaults");
        readback("R1 blank fill");

        // R5 decrement wraps below zero; R11 load
        op_cmd("R11 display addr", 8'h80);
        op_cmd("R5 entry decrement", 8'h04);
        op_wr("R5 wrap down", 8'hA5);
        op_cmd("R5 entry increment", 8'h06);
        op_cmd("R11 display addr 1F", 8'h9F);
        op_wr("R5 wrap up", 8'h3C);
        // R10 pattern wrap and RAM content
        op_cmd("R10 pattern addr", 8'h4F);
        op_wr("R10 pattern wrap", 8'h1F);
        op_cmd("R10 pattern reload", 8'h4F);
        chk("R10 pattern readback", rd_q, 8'h1F);
        op_cmd("R8 cursor in pattern", 8'h14);
        // R6 shift on display writes only
        op_cmd("R6 entry shift", 8'h07);
        op_wr("R6 shift in pattern", 8'h02);
        op_cmd("R11 display addr", 8'h83);
        op_wr("R6 shift left", 8'h41);
        op_rd("R6 no shift on read");
        op_cmd("R6 entry shift right", 8'h05);
        op_wr("R6 shift right", 8'h42);
        // R8 moves, R4 home, R7, R9
        op_cmd("R8 view right", 8'h1C);
        op_cmd("R8 view left", 8'h18);
        op_cmd("R8 cursor right", 8'h14);
        op_cmd("R8 cursor left", 8'h10);
        op_cmd("R7 display control", 8'h0D);
        op_cmd("R9 width 4", 8'h20);
        op_cmd("R9 width 8", 8'h30);
        op_cmd("R4 home 03", 8'h03);
        op_cmd("R12 prefetch at 0", 8'h81);
        op_rd("R12 read stream");
        op_rd("R12 read stream");

        op_clear(1'b1);
        readback("R2 clear fill");

        // Constrained random mix
        for (int it = 0; it < 500; it++) begin
            logic [7:0] r;
            int k;
            r = 8'($urandom);
            k = int'($urandom % 10);
            case (k)
                0, 1: op_wr("R5 R6 random write", r);
                2:    op_rd("R12 random read");
                3:    op_cmd("R11 random display addr", {3'b100, r[4:0]});
                4:    op_cmd("R10 random pattern addr", {2'b01, r[5:0]});
                5:    op_cmd("R5 random entry", {6'b000001, r[1:0]});
                6:    op_cmd("R8 random move", {4'b0001, r[3:0]});
                7:    op_cmd("R7 random display", {5'b00001, r[2:0]});
                8:    op_cmd("R9 random width", {3'b001, r[4:0]});
                default: op_cmd("R4 random home", {7'b0000001, r[0]});
            endcase
            if (it == 250) op_clear(1'b0);
        end
        readback("R2 final readback");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule